// File: doc/BRIEF.md
# Configuration Access Port Decoder

This block sits between a host bus and a set of per-function configuration register files. It routes configuration reads and writes to the selected function. A host reaches a function in one of two ways.

The first way is the legacy I/O pair. A dword written to the address port sets a latched target: enable, bus, device, function and register. A later access to the data port then reads or writes that register. Each register access therefore takes two I/O operations. The second way is a memory window. There, one access carries the whole target in its address, with 4 KiB per function.

The block decodes the target and drives a single request strobe toward the register files. It returns the read data one cycle later. A target that is missing, disabled, on a foreign bus or outside the populated range does not reach a register file. It reads as all ones and ignores writes.

Top module: `cfg_access_decoder`

## Requirements
- R1: A dword I/O write to address 0xCF8 sets the address latch. A dword I/O read of 0xCF8 returns the value most recently written there. The latch is zero after reset.
- R2: An I/O access to 0xCFC-0xCFF while latch bit 31 is set targets the following fields: device from latch bits 15:11, function from bits 10:8, and dword register from bits 7:2. Latch bits 23:16 must equal the parameter OWN_BUS.
- R3: A data-port access while latch bit 31 is clear raises no request strobe. A read of this kind returns 32'hFFFFFFFF.
- R4: A read aimed at an absent function returns 32'hFFFFFFFF. A write aimed at one raises no request strobe. A function is absent when its bit in the fn_present input is 0, or when its bus does not match OWN_BUS.
- R5: Access size is encoded as 0 = byte, 1 = halfword, 2 = dword. The byte enables are the size mask (1, 3 or F) shifted left by address bits 1:0, with lanes above 3 dropped. Read data carries the function's value on the enabled lanes and zero on the other lanes.
- R6: A memory access at an address A with WIN_BASE <= A < WIN_BASE + WIN_BUSES*1 MiB targets the following fields, where O = A - WIN_BASE: bus O[27:20], device O[19:15], function O[14:12], dword register O[11:2]. The register range is 0 to 1023.
- R7: The legacy path reaches only registers 0-63. A window access to register n < 64 presents the same register number n as the legacy path does.
- R8: The block answers every claimed access with rsp_valid exactly one cycle later, with the read data in that same cycle. Any other access gets neither rsp_valid nor a request strobe. The claimed accesses are the latch port, the data port and the window.
- R9: The function index is device*8 + function. An index of NUM_FUNCS or more counts as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access present this cycle |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_valid | output | 1 | Response to the access of the previous cycle |
| rsp_rdata | output | 32 | Lane-aligned read data |
| fn_present | input | NUM_FUNCS | Populated functions, one bit per index |
| fn_req | output | 1 | Register file access strobe |
| fn_write | output | 1 | Strobed access is a write |
| fn_index | output | IDX_W | Target function index |
| fn_reg | output | 10 | Dword register number within the function |
| fn_be | output | 4 | Byte enables |
| fn_wdata | output | 32 | Write data |
| fn_rdata | input | 32 | Combinational read data of the addressed register |

## Verification
The bench targets several corner cases, and each would show a distinct fault.

- A data-port read with the enable bit clear: a design that ignores bit 31 would return real register data where all ones belong.
- A latch that names a device beyond the populated range, or a foreign bus: a design that skips the range check would strobe a nonexistent function index.
- Byte and halfword accesses at 0xCFD through 0xCFF: a design that uses the wrong lane would give shifted byte enables and misplaced read lanes.
- Window accesses to registers above 63, and window accesses that alias legacy registers: a design that drops address bits would show the wrong register number.
- Writes to absent functions and accesses just outside the window: a design that leaks either one would show a stray strobe or response.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

    localparam logic [31:0] LATCH_PORT = 32'h0000_0CF8;
    localparam logic [31:0] DATA_PORT  = 32'h0000_0CFC;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        PATH_NONE   = 2'd0,
        PATH_LATCH  = 2'd1,
        PATH_LEGACY = 2'd2,
        PATH_WINDOW = 2'd3
    } path_e;

    typedef struct packed {
        path_e      path;
        logic       enabled;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [9:0] reg_dw;
        logic [3:0] be;
    } target_t;

    function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
        logic [7:0] base;
        case (size)
            SZ_BYTE: base = 8'h01;
            SZ_HALF: base = 8'h03;
            default: base = 8'h0F;
        endcase
        lane_mask = 4'(base << lo);
    endfunction

    function automatic logic [31:0] lane_bits(input logic [3:0] be);
        for (int i = 0; i < 4; i++) begin
            lane_bits[i*8 +: 8] = {8{be[i]}};
        end
    endfunction

endpackage

// File: rtl/cfgd_addr_latch.sv
module cfgd_addr_latch (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst)       latch_q <= '0;
        else if (load) latch_q <= load_val;
    end

    assert_latch_load_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> (latch_q == $past(load_val)));
endmodule

// File: rtl/cfgd_route_decode.sv
module cfgd_route_decode
    import cfgd_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'hD100_0000,
    parameter int          WIN_BUSES = 1
) (
    input  logic        req_valid,
    input  logic        req_is_io,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] latch_q,
    output target_t     tgt
);
    localparam logic [32:0] WIN_BYTES = 33'(WIN_BUSES) << 20;

    logic [31:0] off;
    logic        in_win;
    logic        unused_bits;

    assign off         = req_addr - WIN_BASE;
    assign in_win      = !req_is_io && (req_addr >= WIN_BASE) && ({1'b0, off} < WIN_BYTES);
    assign unused_bits = ^{latch_q[30:24], latch_q[1:0], off[1:0]};

    always_comb begin
        tgt         = '0;
        tgt.path    = PATH_NONE;
        tgt.be      = lane_mask(req_size, req_addr[1:0]);
        if (req_valid && req_is_io && req_addr == LATCH_PORT && req_size == SZ_WORD) begin
            tgt.path = PATH_LATCH;
        end else if (req_valid && req_is_io && req_addr[31:2] == DATA_PORT[31:2]) begin
            tgt.path    = PATH_LEGACY;
            tgt.enabled = latch_q[31];
            tgt.bus     = latch_q[23:16];
            tgt.dev     = latch_q[15:11];
            tgt.fn      = latch_q[10:8];
            tgt.reg_dw  = {4'b0, latch_q[7:2]};
        end else if (req_valid && in_win) begin
            tgt.path    = PATH_WINDOW;
            tgt.enabled = (off[31:28] == 4'h0);
            tgt.bus     = off[27:20];
            tgt.dev     = off[19:15];
            tgt.fn      = off[14:12];
            tgt.reg_dw  = off[11:2];
        end
    end
endmodule

// File: rtl/cfgd_resp.sv
module cfgd_resp
    import cfgd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  path_e       path,
    input  logic        req_write,
    input  logic        present,
    input  logic [3:0]  be,
    input  logic [31:0] fn_rdata,
    input  logic [31:0] latch_q,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    logic [31:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (!req_write) begin
            case (path)
                PATH_LATCH:  rd_next = latch_q;
                PATH_NONE:   rd_next = '0;
                default:     rd_next = present ? (fn_rdata & lane_bits(be)) : 32'hFFFF_FFFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (path != PATH_NONE);
            rsp_rdata <= rd_next;
        end
    end

    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (path != PATH_NONE) |=> rsp_valid);
    assert_absent_ones_R4: assert property (@(posedge clk) disable iff (rst)
        ((path == PATH_LEGACY || path == PATH_WINDOW) && !req_write && !present)
        |=> (rsp_rdata == 32'hFFFF_FFFF));
endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder
    import cfgd_pkg::*;
#(
    parameter int          NUM_FUNCS = 16,
    parameter logic [7:0]  OWN_BUS   = 8'd0,
    parameter logic [31:0] WIN_BASE  = 32'hD100_0000,
    parameter int          WIN_BUSES = 1,
    localparam int         IDX_W     = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_is_io,
    input  logic                 req_write,
    input  logic [31:0]          req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_FUNCS-1:0] fn_present,
    output logic                 fn_req,
    output logic                 fn_write,
    output logic [IDX_W-1:0]     fn_index,
    output logic [9:0]           fn_reg,
    output logic [3:0]           fn_be,
    output logic [31:0]          fn_wdata,
    input  logic [31:0]          fn_rdata
);
    target_t     tgt;
    logic [31:0] latch_q;
    logic [7:0]  idx_full;
    logic        in_range;
    logic        present;
    logic        data_path;

    cfgd_addr_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (tgt.path == PATH_LATCH && req_write),
        .load_val (req_wdata),
        .latch_q  (latch_q)
    );

    cfgd_route_decode #(.WIN_BASE(WIN_BASE), .WIN_BUSES(WIN_BUSES)) u_dec (
        .req_valid (req_valid),
        .req_is_io (req_is_io),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .latch_q   (latch_q),
        .tgt       (tgt)
    );

    assign idx_full  = {tgt.dev, tgt.fn};
    assign in_range  = ({1'b0, idx_full} < 9'(NUM_FUNCS));
    assign fn_index  = IDX_W'(idx_full);
    assign data_path = (tgt.path == PATH_LEGACY) || (tgt.path == PATH_WINDOW);
    assign present   = data_path && tgt.enabled && (tgt.bus == OWN_BUS)
                       && in_range && fn_present[fn_index];

    assign fn_req   = present;
    assign fn_write = req_write;
    assign fn_reg   = tgt.reg_dw;
    assign fn_be    = tgt.be;
    assign fn_wdata = req_wdata;

    cfgd_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .path      (tgt.path),
        .req_write (req_write),
        .present   (present),
        .be        (tgt.be),
        .fn_rdata  (fn_rdata),
        .latch_q   (latch_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assert_strobe_present_R9: assert property (@(posedge clk) disable iff (rst)
        fn_req |-> (fn_present[fn_index] && (int'(fn_index) < NUM_FUNCS)));
    assert_legacy_low_R7: assert property (@(posedge clk) disable iff (rst)
        (fn_req && req_is_io) |-> (fn_reg[9:6] == 4'h0));
    assert_enable_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (fn_req && req_is_io) |-> latch_q[31]);
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (fn_req && req_size == 2'd0) |-> ($countones(fn_be) == 1));
    assert_no_stray_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !fn_req);
endmodule

// File: tb/cfg_access_decoder_tb.sv
module cfg_access_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_io, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NF-1:0] fn_present;
    logic        fn_req, fn_write;
    logic [3:0]  fn_index;
    logic [9:0]  fn_reg;
    logic [3:0]  fn_be;
    logic [31:0] fn_wdata, fn_rdata;

    int tests = 0;
    int fails = 0;
    logic [31:0] mlatch;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_decoder dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fn_present(fn_present), .fn_req(fn_req), .fn_write(fn_write),
        .fn_index(fn_index), .fn_reg(fn_reg), .fn_be(fn_be),
        .fn_wdata(fn_wdata), .fn_rdata(fn_rdata)
    );

    function automatic logic [31:0] reg_val(input logic [3:0] idx, input logic [9:0] r);
        return {4'hA, idx, 6'h0, r, 8'h5C};
    endfunction

    assign fn_rdata = reg_val(fn_index, fn_reg);

    function automatic logic [3:0] mask_of(input logic [1:0] sz, input logic [1:0] lo);
        logic [7:0] b;
        b = (sz == 2'd0) ? 8'h01 : (sz == 2'd1) ? 8'h03 : 8'h0F;
        return 4'(b << lo);
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input string tag, input logic io, input logic wr,
                          input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] wd);
        logic claim, is_latch, en, pres, e_req;
        logic [7:0] bus, idx8;
        logic [9:0] rg;
        logic [3:0] be;
        logic [31:0] e_rd, off;
        logic s_req, s_wr;
        logic [3:0] s_idx, s_be;
        logic [9:0] s_reg;
        claim = 0; is_latch = 0; en = 0; bus = 0; idx8 = 0; rg = 0;
        be = mask_of(sz, addr[1:0]);
        off = addr - 32'hD100_0000;
        if (io && addr == 32'hCF8 && sz == 2'd2) begin
            claim = 1; is_latch = 1;
        end else if (io && addr[31:2] == 30'h33F) begin
            claim = 1; en = mlatch[31]; bus = mlatch[23:16];
            idx8 = {mlatch[15:11], mlatch[10:8]}; rg = {4'b0, mlatch[7:2]};
        end else if (!io && addr >= 32'hD100_0000 && addr < 32'hD110_0000) begin
            claim = 1; en = 1; bus = off[27:20]; idx8 = off[19:12]; rg = off[11:2];
        end
        pres  = claim && !is_latch && en && bus == 8'd0 && idx8 < 8'(NF) && fn_present[idx8[3:0]];
        e_req = pres;
        if (wr) e_rd = 32'h0;
        else if (is_latch) e_rd = mlatch;
        else e_rd = pres ? (reg_val(idx8[3:0], rg) & lanes(be)) : 32'hFFFF_FFFF;

        @(negedge clk);
        req_valid = 1; req_is_io = io; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        #1;
        s_req = fn_req; s_wr = fn_write; s_idx = fn_index; s_reg = fn_reg; s_be = fn_be;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check(s_req == e_req, {tag, " strobe"}, 32'(s_req), 32'(e_req));
        if (e_req && s_req) begin
            check(s_idx == idx8[3:0], {tag, " index"}, 32'(s_idx), 32'(idx8));
            check(s_reg == rg, {tag, " reg"}, 32'(s_reg), 32'(rg));
            check(s_be == be, {tag, " be"}, 32'(s_be), 32'(be));
            check(s_wr == wr, {tag, " dir"}, 32'(s_wr), 32'(wr));
        end
        check(rsp_valid == claim, {tag, " rsp_valid"}, 32'(rsp_valid), 32'(claim));
        if (claim && !wr) check(rsp_rdata == e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
        if (is_latch && wr) mlatch = wd;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        fn_present = 16'hB7DF;
        req_valid = 0; req_is_io = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
        mlatch = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check(rsp_valid == 0, "R8 reset rsp_valid", 32'(rsp_valid), 0);
        access("R1 reset latch read", 1, 0, 32'hCF8, 2, 0);
        access("R1 latch write", 1, 1, 32'hCF8, 2, 32'h8000_010C);
        access("R1 latch readback", 1, 0, 32'hCF8, 2, 0);
        access("R2 legacy dword read", 1, 0, 32'hCFC, 2, 0);
        access("R2 legacy write", 1, 1, 32'hCFC, 2, 32'h1234_5678);
        access("R5 byte lane 2", 1, 0, 32'hCFE, 0, 0);
        access("R5 byte lane 3", 1, 0, 32'hCFF, 0, 0);
        access("R5 half lane 1", 1, 0, 32'hCFD, 1, 0);
        access("R3 latch disable", 1, 1, 32'hCF8, 2, 32'h0000_010C);
        access("R3 disabled read", 1, 0, 32'hCFC, 2, 0);
        access("R3 disabled write", 1, 1, 32'hCFC, 2, 32'hFFFF_0000);
        access("R4 latch absent fn", 1, 1, 32'hCF8, 2, 32'h8000_0500);
        access("R4 absent read", 1, 0, 32'hCFC, 2, 0);
        access("R4 absent write", 1, 1, 32'hCFC, 2, 32'hDEAD_BEEF);
        access("R4 latch foreign bus", 1, 1, 32'hCF8, 2, 32'h8001_0100);
        access("R4 foreign bus read", 1, 0, 32'hCFC, 2, 0);
        access("R9 latch dev2", 1, 1, 32'hCF8, 2, 32'h8000_1000);
        access("R9 out of range read", 1, 0, 32'hCFC, 2, 0);
        access("R6 window high reg", 0, 0, 32'hD100_1140, 2, 0);
        access("R6 window top reg", 0, 0, 32'hD100_FFFC, 2, 0);
        access("R7 window alias", 0, 0, 32'hD100_100C, 2, 0);
        access("R7 latch alias", 1, 1, 32'hCF8, 2, 32'h8000_010C);
        access("R7 legacy alias", 1, 0, 32'hCFC, 2, 0);
        access("R4 window absent", 0, 0, 32'hD100_5000, 2, 0);
        access("R8 unclaimed io", 1, 0, 32'h0000_0080, 2, 0);
        access("R8 below window", 0, 0, 32'hD0FF_FFFC, 2, 0);
        access("R8 above window", 0, 0, 32'hD110_0000, 2, 0);
        access("R8 latch byte not claimed", 1, 1, 32'hCF8, 0, 32'h1);
        for (int i = 0; i < 400; i++) begin
            int kind;
            logic [31:0] r;
            kind = $urandom_range(0, 3);
            r = $urandom;
            case (kind)
                0: access("R1 rand latch", 1, 1, 32'hCF8, 2,
                          {r[31], 7'h0, (r[6] ? 8'h00 : 8'h01), 1'b0, r[14:0]});
                1: access("R2 rand data", 1, r[0], {30'h33F, r[2:1]}, 2'(r[4:3] % 3), r);
                2: access("R6 rand window", 0, r[0], 32'hD100_0000 + {12'h0, 2'b00, r[17:0]},
                          2'(r[21:20] % 3), r);
                default: access("R8 rand other", r[0], r[1], r, 2, r);
            endcase
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule